// File: doc/BRIEF.md
# Non-Overlapping Timed Pattern Generator

This block drives eight output pins with a pattern that changes on a timer. A free-running counter is compared against two values. The period compare clears the counter and starts a pattern update. The margin compare comes a set number of counts later and acts as the second phase of the update. Software writes the next pattern into a staging register. Each pin has an enable bit, and each group of four pins has a mode bit that picks one of two update styles.

In normal mode, every enabled pin in a group takes its staged value on the period match. In non-overlap mode, the update is split in two. Pins that drop from 1 to 0 fall on the period match. Pins that rise from 0 to 1 rise on the following margin match. This leaves a dead band, so two pins of a group are never high together during the change. The margin match also raises a sticky interrupt flag. The flag tells software it may stage the next pattern, and software clears it by writing 1. Before the counter starts, software can load the pins directly with a starting value.

Top module: `nov_pattern_unit`

## Requirements
- R1: The counter increments by one on each cycle where the start bit (address 5, bit 0) is 1 and `tick_en` is 1. Otherwise the counter holds its value.
- R2: When the counter equals the period (address 3), a period match occurs. On that match the counter returns to 0, so matches repeat every period+1 counted ticks.
- R3: A group whose mode bit is 0 is in normal mode. On each period match, every enabled pin of that group takes its bit from the staged pattern (address 0).
- R4: A group whose mode bit is 1 is in non-overlap mode. On a period match, enabled pins whose staged bit is 0 go low. Enabled pins that are low and whose staged bit is 1 go high on the next margin match (counter equal to address 4). They use the staged value captured at the period match.
- R5: A pin whose enable bit (address 1, bit i for pin i) is 0 keeps its current value on every match.
- R6: Mode bit g (address 2) controls pins 4g+3 down to 4g. Group 0 is pins 3:0 and group 1 is pins 7:4. The two groups can run in different modes at the same time.
- R7: `irq` goes high in the cycle after a margin match. It stays high until a write to address 7 with data bit 0 equal to 1. If a clear write and a margin match fall in the same cycle, the flag stays set.
- R8: If the margin is not smaller than the period, no margin match occurs and `irq` is never set. Rises still pending from a period match are then applied on the next period match.
- R9: A write to address 6 loads `pat_out` directly while the start bit is 0. The same write has no effect while the start bit is 1.
- R10: After reset, `pat_out` is 0, `irq` is 0, and the counter and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| irq | output | 1 | Sticky margin-match interrupt flag |
| pat_out | output | 8 | Pattern output pins |

## Verification
Two events can land in the same cycle: the margin match that sets the interrupt flag, and the software write that clears it. The bench counts cycles from the start write. It then times the clear write so that its clock edge falls exactly on the second margin match of the run. The flag must read 1 after that edge. The flag must also read 0 after an earlier clear that had no match beside it.

// File: rtl/nov_pkg.sv
package nov_pkg;
  typedef enum logic [2:0] {
    ADR_NEXT   = 3'd0,
    ADR_ENABLE = 3'd1,
    ADR_MODE   = 3'd2,
    ADR_PERIOD = 3'd3,
    ADR_MARGIN = 3'd4,
    ADR_START  = 3'd5,
    ADR_INIT   = 3'd6,
    ADR_ACK    = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/nov_timer.sv
module nov_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] margin,
  output logic [CNT_W-1:0] cnt,
  output logic             match_a,
  output logic             match_b
);
  // A margin match is only possible when the margin lies inside the period.
  function automatic logic margin_hit(input logic [CNT_W-1:0] c,
                                      input logic [CNT_W-1:0] m,
                                      input logic [CNT_W-1:0] p);
    return (c == m) && (m < p);
  endfunction

  logic step;
  assign step    = run && tick_en;
  assign match_b = step && (cnt == period);
  assign match_a = step && margin_hit(cnt, margin, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (match_b) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end

  assert_wrap_on_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_b |=> (cnt == '0));
  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && tick_en) |=> $stable(cnt));
  assert_ab_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_a && match_b));
endmodule

// File: rtl/nov_group.sv
module nov_group #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nov_mode,
  input  logic [GW-1:0] en,
  input  logic [GW-1:0] nd,
  input  logic          init_we,
  input  logic [GW-1:0] init_data,
  input  logic          match_a,
  input  logic          match_b,
  output logic [GW-1:0] out
);
  logic [GW-1:0] out_q, pend_q, mid;

  // Enabled bits whose staged value is 0 drop.
  function automatic logic [GW-1:0] drop_bits(input logic [GW-1:0] cur,
                                              input logic [GW-1:0] e,
                                              input logic [GW-1:0] d);
    return cur & ~(e & ~d);
  endfunction
  // Enabled bits that are low and staged high, deferred to the margin match.
  function automatic logic [GW-1:0] rise_bits(input logic [GW-1:0] cur,
                                              input logic [GW-1:0] e,
                                              input logic [GW-1:0] d);
    return e & d & ~cur;
  endfunction
  function automatic logic [GW-1:0] merge_bits(input logic [GW-1:0] cur,
                                               input logic [GW-1:0] e,
                                               input logic [GW-1:0] d);
    return (cur & ~e) | (d & e);
  endfunction

  // Rises left over from a missed margin match are applied first.
  assign mid = out_q | pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      pend_q <= '0;
    end else if (init_we) begin
      out_q  <= init_data;
      pend_q <= '0;
    end else if (match_b) begin
      if (nov_mode) begin
        out_q  <= drop_bits(mid, en, nd);
        pend_q <= rise_bits(mid, en, nd);
      end else begin
        out_q  <= merge_bits(mid, en, nd);
        pend_q <= '0;
      end
    end else if (match_a) begin
      out_q  <= out_q | pend_q;
      pend_q <= '0;
    end
  end

  assign out = out_q;

  assert_quiet_between_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_a && !match_b && !init_we) |=> $stable(out_q));
  assert_no_fresh_rise_at_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_b && nov_mode && !init_we) |=> ((out_q & ~$past(out_q | pend_q)) == '0));
  assert_disabled_pins_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_b && !init_we) |=> (((out_q ^ $past(mid)) & ~$past(en)) == '0));
endmodule

// File: rtl/nov_irq.sv
module nov_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/nov_pattern_unit.sv
module nov_pattern_unit #(
  parameter int CNT_W = 16,
  parameter int GRP_W = 4,
  parameter int N_GRP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_en,
  input  logic                   wr_en,
  input  logic [2:0]             wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  output logic                   irq,
  output logic [GRP_W*N_GRP-1:0] pat_out
);
  import nov_pkg::*;
  localparam int DW = GRP_W * N_GRP;

  logic [DW-1:0]    nd_q, en_q;
  logic [N_GRP-1:0] mode_q;
  logic [CNT_W-1:0] period_q, margin_q, cnt;
  logic             start_q, match_a, match_b, init_we, ack_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nd_q     <= '0;
      en_q     <= '0;
      mode_q   <= '0;
      period_q <= '0;
      margin_q <= '0;
      start_q  <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        ADR_NEXT:   nd_q     <= wr_data[DW-1:0];
        ADR_ENABLE: en_q     <= wr_data[DW-1:0];
        ADR_MODE:   mode_q   <= wr_data[N_GRP-1:0];
        ADR_PERIOD: period_q <= wr_data;
        ADR_MARGIN: margin_q <= wr_data;
        ADR_START:  start_q  <= wr_data[0];
        default: ;
      endcase
    end
  end

  assign init_we = wr_en && (reg_addr_e'(wr_addr) == ADR_INIT) && !start_q;
  assign ack_we  = wr_en && (reg_addr_e'(wr_addr) == ADR_ACK) && wr_data[0];

  nov_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(start_q), .tick_en(tick_en),
    .period(period_q), .margin(margin_q), .cnt(cnt),
    .match_a(match_a), .match_b(match_b)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    nov_group #(.GW(GRP_W)) grp_i (
      .clk(clk), .rst_n(rst_n), .nov_mode(mode_q[g]),
      .en(en_q[g*GRP_W +: GRP_W]), .nd(nd_q[g*GRP_W +: GRP_W]),
      .init_we(init_we), .init_data(wr_data[g*GRP_W +: GRP_W]),
      .match_a(match_a), .match_b(match_b),
      .out(pat_out[g*GRP_W +: GRP_W])
    );
  end

  nov_irq irq_i (
    .clk(clk), .rst_n(rst_n), .set(match_a), .clr(ack_we), .flag(irq)
  );

  assert_init_ignored_when_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !match_a && !match_b) |=> $stable(pat_out));
  assert_no_irq_bad_margin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (margin_q >= period_q) |-> !match_a);
endmodule

// File: tb/nov_pattern_unit_tb.sv
module nov_pattern_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        irq;
  logic [7:0]  pat_out;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  nov_pattern_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .pat_out(pat_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge; returns at the following negedge.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick_en = 1'b1; wr_en = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic setup(input logic [15:0] p, input logic [15:0] m, input logic [1:0] mode,
                       input logic [7:0] en, input logic [7:0] init, input logic [7:0] nd);
    wr(3, p); wr(4, m); wr(2, {14'd0, mode}); wr(1, {8'd0, en});
    wr(6, {8'd0, init}); wr(0, {8'd0, nd});
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 pat_out", {8'd0, pat_out}, 16'h0000);
    check("R10 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_normal();
    do_reset();
    setup(5, 2, 2'b00, 8'hFF, 8'h0F, 8'hA5);
    check("R9 init load", {8'd0, pat_out}, 16'h000F);
    wr(5, 1);            // t=0
    step(5);             // t=5
    check("R3 before match", {8'd0, pat_out}, 16'h000F);
    step(1);             // t=6
    check("R3 normal update", {8'd0, pat_out}, 16'h00A5);
    wr(0, 16'h003C);     // t=7
    step(5);             // t=12
    check("R2 second period", {8'd0, pat_out}, 16'h003C);
  endtask

  task automatic t_nov();
    do_reset();
    setup(5, 2, 2'b01, 8'h0F, 8'h53, 8'hAC);
    wr(5, 1);
    step(2);
    check("R7 irq before margin", {15'd0, irq}, 16'h0000);
    step(1);             // t=3
    check("R7 irq on margin", {15'd0, irq}, 16'h0001);
    step(3);             // t=6
    check("R4 falls only", {8'd0, pat_out}, 16'h0050);
    step(2);             // t=8
    check("R4 dead band", {8'd0, pat_out}, 16'h0050);
    step(1);             // t=9
    check("R4 rises on margin", {8'd0, pat_out}, 16'h005C);
    check("R5 disabled group hold", {12'd0, pat_out[7:4]}, 16'h0005);
  endtask

  task automatic t_mixed();
    do_reset();
    setup(5, 2, 2'b01, 8'hFF, 8'h31, 8'hC2);
    wr(5, 1);
    step(6);
    check("R6 mixed after period", {8'd0, pat_out}, 16'h00C0);
    step(3);
    check("R6 mixed after margin", {8'd0, pat_out}, 16'h00C2);
  endtask

  task automatic t_irq();
    do_reset();
    setup(5, 2, 2'b00, 8'h00, 8'h00, 8'h00);
    wr(5, 1);
    step(3);             // t=3
    check("R7 set", {15'd0, irq}, 16'h0001);
    wr(7, 1);            // t=4
    check("R7 clear", {15'd0, irq}, 16'h0000);
    step(4);             // t=8
    check("R7 stays clear", {15'd0, irq}, 16'h0000);
    wr(7, 1);            // edge 9 is a margin match
    check("R7 set wins over clear", {15'd0, irq}, 16'h0001);
    wr(7, 0);
    check("R7 write of 0 keeps flag", {15'd0, irq}, 16'h0001);
  endtask

  task automatic t_bad_margin();
    do_reset();
    setup(4, 6, 2'b01, 8'h0F, 8'h01, 8'h02);
    wr(5, 1);
    step(5);
    check("R8 fall at period", {8'd0, pat_out}, 16'h0000);
    step(4);             // t=9
    check("R8 no margin rise", {8'd0, pat_out}, 16'h0000);
    check("R8 no irq", {15'd0, irq}, 16'h0000);
    step(1);             // t=10
    check("R8 rise at next period", {8'd0, pat_out}, 16'h0002);
  endtask

  task automatic t_gate();
    do_reset();
    setup(5, 2, 2'b00, 8'hFF, 8'h00, 8'hFF);
    wr(5, 1);
    step(2);
    tick_en = 1'b0;
    step(3);
    tick_en = 1'b1;
    step(3);             // t=8
    check("R1 tick gate delays match", {8'd0, pat_out}, 16'h0000);
    step(1);             // t=9
    check("R1 match after gated ticks", {8'd0, pat_out}, 16'h00FF);
    wr(6, 16'h0000);     // running: ignored
    check("R9 init ignored while running", {8'd0, pat_out}, 16'h00FF);
    wr(5, 0);
    step(10);
    check("R1 stopped holds", {8'd0, pat_out}, 16'h00FF);
    wr(6, 16'h003C);
    step(10);
    check("R1 stopped no match", {8'd0, pat_out}, 16'h003C);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_normal();
    t_nov();
    t_mixed();
    t_irq();
    t_bad_margin();
    t_gate();
    report();
  end
endmodule